// File: doc/BRIEF.md
# Data Translation Shortcut Cache

This block sits beside a data MMU's main translation array and keeps the two translation entries used most recently. A repeated data access can then be translated without the full lookup. Each access presents a control-state word, an address-space tag, a virtual address, a byte count, a write flag and an implicit flag. The block answers in the same cycle. It returns a hit flag, the physical address and an uncacheable flag.

When the full translation path resolves an access, it presents the winning entry on the fill inputs. The entry goes to the most-recently-used slot, and the previous occupant moves down one place. Any write to the main array or to the context registers must pulse the invalidate input. The cache is also ignored whenever the control-state word differs from the one captured at the last fill. The main array, the page walk and fault reporting are not part of this block.

Top module: `xlat_shortcut`

## Requirements
- R1: After reset no cached entry can hit. Only the hypervisor implicit path of R3 returns hit_o=1.
- R2: An access is unaligned when vaddr_i AND (size_i-1) is nonzero. An unaligned access always gives hit_o=0, including on the hypervisor path.
- R3: If state_i bit 0 is 1 and implicit_i is 1, an aligned access hits. Its paddr_o is vaddr_i[39:0] and uncache_o is 0, and no slot is consulted.
- R4: Slots are consulted only while the cache is valid and state_i equals the state word captured at the most recent fill. Any other state_i value misses.
- R5: A slot matches when its tag equals asi_i, page_start < vaddr_i+size_i, and page_start+mask+1 > vaddr_i. The page size is the mask plus one.
- R6: A write (write_i=1) matches only a slot whose writable bit is set. Reads ignore the writable bit.
- R7: When both slots match, slot 0 (the most recently filled) supplies the result.
- R8: On a hit, paddr_o = (pbase AND NOT mask) OR (vaddr_i AND mask), over the 40 physical address bits.
- R9: uncache_o is 1 on a slot hit when the entry's side-effect bit is 1 or bit 39 of its physical base is 1.
- R10: A fill of a new entry moves slot 0 to slot 1, drops the old slot 1 and writes the entry into slot 0. Entry identity is page start, mask and physical base together.
- R11: A fill whose entry already sits in a slot of a valid cache changes no slot, and the stored tag is not rewritten. The state word is still captured.
- R12: A fill done with implicit_i=1 stores tag 0 in slot 0, whatever asi_i is.
- R13: inv_i marks the cache invalid. The next fill clears slot 1 before it writes slot 0, so only the new entry can hit.
- R14: When inv_i and fill_i are both high in the same cycle, the invalidate wins and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inv_i | input | 1 | Invalidate the cache |
| state_i | input | 64 | Control-state word; bit 0 is the hypervisor bit |
| asi_i | input | 8 | Address-space tag of the access |
| vaddr_i | input | 64 | Virtual byte address |
| size_i | input | 8 | Access size in bytes, a power of two |
| write_i | input | 1 | Access is a store |
| implicit_i | input | 1 | Access uses the implicit address space |
| fill_i | input | 1 | Store the fill entry at the clock edge |
| fill_vstart_i | input | 64 | Fill: virtual page start |
| fill_mask_i | input | 64 | Fill: page offset mask (page size minus 1) |
| fill_pbase_i | input | 40 | Fill: physical page base |
| fill_wr_i | input | 1 | Fill: page is writable |
| fill_se_i | input | 1 | Fill: page has side effects |
| hit_o | output | 1 | Translation supplied this cycle |
| paddr_o | output | 40 | Physical address |
| uncache_o | output | 1 | Access must bypass caches |

## Verification
Three situations are hard to reach from the ports. The first is a duplicate fill of the entry that already sits in slot 1, because with or without duplicate skipping the same pair of pages stays resident. The stimulus refills that entry under a different tag and then shows that the old tag still hits and the new one misses. The second is slot priority, which is reached by filling two overlapping pages with different physical bases. The third is clearing slot 1 after an invalidate: three fills are chained so that a known second entry would otherwise survive.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int VA_W  = 64;
  localparam int PA_W  = 40;
  localparam int ST_W  = 64;
  localparam int ASI_W = 8;
  localparam int SZ_W  = 8;
  localparam int UC_BIT = 39;

  typedef struct packed {
    logic             vld;
    logic [VA_W-1:0]  vstart;
    logic [VA_W-1:0]  mask;
    logic [PA_W-1:0]  pbase;
    logic             wr;
    logic             se;
    logic [ASI_W-1:0] tag;
  } xs_entry_t;
endpackage

// File: rtl/xs_match.sv
module xs_match
  import xs_pkg::*;
(
  input  xs_entry_t        ent_i,
  input  logic [ASI_W-1:0] asi_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic             write_i,
  output logic             hit_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             uncache_o
);
  logic [VA_W:0] req_end, page_end;

  always_comb begin
    req_end  = {1'b0, vaddr_i} + {{(VA_W+1-SZ_W){1'b0}}, size_i};
    page_end = {1'b0, ent_i.vstart} + {1'b0, ent_i.mask} + 1'b1;
    hit_o = ent_i.vld && (ent_i.tag == asi_i)
         && ({1'b0, ent_i.vstart} < req_end)
         && (page_end > {1'b0, vaddr_i})
         && (!write_i || ent_i.wr);
    paddr_o   = (ent_i.pbase & ~ent_i.mask[PA_W-1:0]) | (vaddr_i[PA_W-1:0] & ent_i.mask[PA_W-1:0]);
    uncache_o = ent_i.se | ent_i.pbase[UC_BIT];
  end
endmodule

// File: rtl/xs_store.sv
module xs_store
  import xs_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  inv_i,
  input  logic                  fill_i,
  input  logic [ST_W-1:0]       state_i,
  input  xs_entry_t             new_i,
  output xs_entry_t [NSLOT-1:0] slot_o,
  output logic                  valid_o,
  output logic [ST_W-1:0]       state_o
);
  xs_entry_t [NSLOT-1:0] slot_q;
  logic                  valid_q;
  logic [ST_W-1:0]       state_q;
  logic                  dup;

  always_comb begin
    dup = 1'b0;
    for (int k = 0; k < NSLOT; k++)
      if (slot_q[k].vld && slot_q[k].vstart == new_i.vstart &&
          slot_q[k].mask == new_i.mask && slot_q[k].pbase == new_i.pbase)
        dup = 1'b1;
    dup = dup & valid_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      valid_q <= 1'b0;
      state_q <= '0;
    end else if (inv_i) begin
      valid_q <= 1'b0;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      state_q <= state_i;
      if (!valid_q) begin
        for (int k = 1; k < NSLOT; k++) slot_q[k].vld <= 1'b0;
        slot_q[0] <= new_i;
      end else if (!dup) begin
        for (int k = 1; k < NSLOT; k++) slot_q[k] <= slot_q[k-1];
        slot_q[0] <= new_i;
      end
    end
  end

  assign slot_o  = slot_q;
  assign valid_o = valid_q;
  assign state_o = state_q;

  a_r13_inv_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> !valid_q);
  a_r10_mru_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !inv_i && valid_q && !dup) |=> (slot_q[1] == $past(slot_q[0])));
  a_r11_dup_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !inv_i && dup) |=> $stable(slot_q));
  a_r14_inv_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && inv_i) |=> (!valid_q && $stable(slot_q)));
endmodule

// File: rtl/xlat_shortcut.sv
module xlat_shortcut
  import xs_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inv_i,
  input  logic [63:0]      state_i,
  input  logic [7:0]       asi_i,
  input  logic [63:0]      vaddr_i,
  input  logic [7:0]       size_i,
  input  logic             write_i,
  input  logic             implicit_i,
  input  logic             fill_i,
  input  logic [63:0]      fill_vstart_i,
  input  logic [63:0]      fill_mask_i,
  input  logic [39:0]      fill_pbase_i,
  input  logic             fill_wr_i,
  input  logic             fill_se_i,
  output logic             hit_o,
  output logic [39:0]      paddr_o,
  output logic             uncache_o
);
  xs_entry_t [NSLOT-1:0] slot;
  xs_entry_t             new_ent;
  logic                  c_valid;
  logic [ST_W-1:0]       c_state;
  logic [NSLOT-1:0]      s_hit, s_uc;
  logic [PA_W-1:0]       s_pa [NSLOT];
  logic                  unaligned, hyp, use_cache;

  always_comb begin
    new_ent        = '0;
    new_ent.vld    = 1'b1;
    new_ent.vstart = fill_vstart_i;
    new_ent.mask   = fill_mask_i;
    new_ent.pbase  = fill_pbase_i;
    new_ent.wr     = fill_wr_i;
    new_ent.se     = fill_se_i;
    new_ent.tag    = implicit_i ? '0 : asi_i;
  end

  xs_store #(.NSLOT(NSLOT)) u_store (
    .clk_i, .rst_ni, .inv_i, .fill_i, .state_i,
    .new_i(new_ent), .slot_o(slot), .valid_o(c_valid), .state_o(c_state)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    xs_match u_match (
      .ent_i(slot[g]), .asi_i, .vaddr_i, .size_i, .write_i,
      .hit_o(s_hit[g]), .paddr_o(s_pa[g]), .uncache_o(s_uc[g])
    );
  end

  always_comb begin
    unaligned = |(vaddr_i & {{(VA_W-SZ_W){1'b0}}, size_i - 1'b1});
    hyp       = state_i[0] & implicit_i;
    use_cache = c_valid && (c_state == state_i);
    hit_o     = 1'b0;
    paddr_o   = '0;
    uncache_o = 1'b0;
    if (!unaligned) begin
      if (hyp) begin
        hit_o   = 1'b1;
        paddr_o = vaddr_i[PA_W-1:0];
      end else if (use_cache) begin
        for (int k = NSLOT-1; k >= 0; k--)
          if (s_hit[k]) begin
            hit_o     = 1'b1;
            paddr_o   = s_pa[k];
            uncache_o = s_uc[k];
          end
      end
    end
  end

  a_r2_unaligned_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(vaddr_i & ({56'd0, size_i} - 64'd1))) |-> !hit_o);
  a_r4_state_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !(state_i[0] && implicit_i)) |-> (c_valid && c_state == state_i));
  a_r3_hyp_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && state_i[0] && implicit_i) |-> (paddr_o == vaddr_i[39:0] && !uncache_o));
  a_r1_no_hit_after_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> (!hit_o || (state_i[0] && implicit_i)));
endmodule

// File: tb/sim_xlat_shortcut.sv
module sim_xlat_shortcut;
  logic clk = 0, rst_n = 0;
  logic inv = 0, wr = 0, impl = 0, fill = 0, f_wr = 0, f_se = 0;
  logic [63:0] state = 0, va = 0, f_vs = 0, f_mk = 0;
  logic [7:0]  asi = 0, size = 1;
  logic [39:0] f_pb = 0;
  logic hit, uc;
  logic [39:0] pa;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [63:0] S1 = 64'h0000_0000_0001_00F0;
  localparam logic [63:0] S2 = 64'h0000_0002_0001_00F0;

  always #4 clk = ~clk;

  xlat_shortcut u0 (
    .clk_i(clk), .rst_ni(rst_n), .inv_i(inv), .state_i(state), .asi_i(asi),
    .vaddr_i(va), .size_i(size), .write_i(wr), .implicit_i(impl), .fill_i(fill),
    .fill_vstart_i(f_vs), .fill_mask_i(f_mk), .fill_pbase_i(f_pb),
    .fill_wr_i(f_wr), .fill_se_i(f_se), .hit_o(hit), .paddr_o(pa), .uncache_o(uc)
  );

  task automatic chk(string r, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", r, got, exp);
    end
  endtask

  task automatic look(logic [63:0] s, logic [7:0] a, logic [63:0] v, logic [7:0] z,
                      logic w, logic im);
    @(negedge clk);
    state = s; asi = a; va = v; size = z; wr = w; impl = im;
    #1;
  endtask

  task automatic do_fill(logic [63:0] s, logic [7:0] a, logic im, logic [63:0] vs,
                         logic [63:0] mk, logic [39:0] pb, logic w, logic se, logic iv);
    @(negedge clk);
    state = s; asi = a; impl = im; f_vs = vs; f_mk = mk; f_pb = pb;
    f_wr = w; f_se = se; fill = 1; inv = iv;
    @(negedge clk);
    fill = 0; inv = 0; impl = 0;
  endtask

  task automatic t_reset;
    look(S1, 8'h80, 64'h1000_0000, 8'd4, 0, 0);
    chk("R1 miss after reset", hit, 0);
  endtask

  task automatic t_hyp;
    look(64'h1, 8'h04, 64'hFFFF_1234_5678_9AB0, 8'd8, 0, 1);
    chk("R3 hyp hit", hit, 1);
    chk("R3 hyp pa", pa, 40'h34_5678_9AB0);
    chk("R3 hyp uc", uc, 0);
    look(64'h1, 8'h04, 64'hFFFF_1234_5678_9AB4, 8'd8, 0, 1);
    chk("R2 unaligned hyp miss", hit, 0);
  endtask

  task automatic t_basic;
    do_fill(S1, 8'h80, 0, 64'h1000_0000, 64'h1FFF, 40'h02_0000_4000, 1, 0, 0);
    look(S1, 8'h80, 64'h1000_0123, 8'd1, 0, 0);
    chk("R5 hit", hit, 1);
    chk("R8 pa", pa, 40'h02_0000_4123);
    chk("R9 uc clear", uc, 0);
    look(S1, 8'h81, 64'h1000_0123, 8'd1, 0, 0);
    chk("R5 tag mismatch", hit, 0);
    look(S2, 8'h80, 64'h1000_0123, 8'd1, 0, 0);
    chk("R4 state mismatch", hit, 0);
    look(S1, 8'h80, 64'h0FFF_FFF8, 8'd8, 0, 0);
    chk("R5 below page", hit, 0);
    look(S1, 8'h80, 64'h1000_1FF8, 8'd8, 0, 0);
    chk("R5 last dword hit", hit, 1);
    chk("R8 last dword pa", pa, 40'h02_0000_5FF8);
    look(S1, 8'h80, 64'h1000_2000, 8'd8, 0, 0);
    chk("R5 above page", hit, 0);
    look(S1, 8'h80, 64'h1000_0122, 8'd4, 0, 0);
    chk("R2 unaligned miss", hit, 0);
  endtask

  task automatic t_write;
    do_fill(S1, 8'h80, 0, 64'h2000_0000, 64'hFFF, 40'h80_0000_0000, 0, 0, 0);
    look(S1, 8'h80, 64'h2000_0010, 8'd4, 0, 0);
    chk("R6 read ro hit", hit, 1);
    chk("R9 pa bit39 uc", uc, 1);
    look(S1, 8'h80, 64'h2000_0010, 8'd4, 1, 0);
    chk("R6 write ro miss", hit, 0);
    look(S1, 8'h80, 64'h1000_0040, 8'd4, 1, 0);
    chk("R10 slot1 write hit", hit, 1);
    chk("R10 slot1 pa", pa, 40'h02_0000_4040);
  endtask

  task automatic t_se;
    do_fill(S1, 8'h80, 0, 64'h3000_0000, 64'hFFFF, 40'h00_5555_0000, 1, 1, 0);
    look(S1, 8'h80, 64'h1000_0040, 8'd4, 0, 0);
    chk("R10 oldest dropped", hit, 0);
    look(S1, 8'h80, 64'h3000_1010, 8'd4, 0, 0);
    chk("R9 se uc", uc, 1);
    chk("R8 64K pa", pa, 40'h00_5555_1010);
    look(S1, 8'h80, 64'h2000_0010, 8'd4, 0, 0);
    chk("R10 slot1 kept", hit, 1);
  endtask

  task automatic t_dup;
    do_fill(S1, 8'h90, 0, 64'h2000_0000, 64'hFFF, 40'h80_0000_0000, 0, 0, 0);
    look(S1, 8'h80, 64'h2000_0010, 8'd4, 0, 0);
    chk("R11 old tag kept", hit, 1);
    look(S1, 8'h90, 64'h2000_0010, 8'd4, 0, 0);
    chk("R11 new tag not stored", hit, 0);
    look(S1, 8'h80, 64'h3000_0010, 8'd4, 0, 0);
    chk("R11 other slot kept", hit, 1);
  endtask

  task automatic t_prio;
    do_fill(S1, 8'h80, 0, 64'h3000_0000, 64'hFFF, 40'h00_0777_7000, 1, 0, 0);
    look(S1, 8'h80, 64'h3000_0010, 8'd4, 0, 0);
    chk("R7 slot0 pa", pa, 40'h00_0777_7010);
    chk("R7 slot0 uc", uc, 0);
    look(S1, 8'h80, 64'h3000_1010, 8'd4, 0, 0);
    chk("R7 slot1 only hit", hit, 1);
    chk("R7 slot1 pa", pa, 40'h00_5555_1010);
  endtask

  task automatic t_implicit;
    do_fill(S1, 8'h80, 1, 64'h4000_0000, 64'hFFF, 40'h00_0000_9000, 1, 0, 0);
    look(S1, 8'h80, 64'h4000_0004, 8'd4, 0, 0);
    chk("R12 asi tag not stored", hit, 0);
    look(S1, 8'h00, 64'h4000_0004, 8'd4, 0, 0);
    chk("R12 zero tag hit", hit, 1);
    chk("R12 pa", pa, 40'h00_0000_9004);
  endtask

  task automatic t_inv;
    @(negedge clk); inv = 1;
    @(negedge clk); inv = 0;
    look(S1, 8'h00, 64'h4000_0004, 8'd4, 0, 0);
    chk("R13 miss after inv", hit, 0);
    do_fill(S2, 8'h80, 0, 64'h1000_0000, 64'h1FFF, 40'h02_0000_4000, 1, 0, 0);
    look(S2, 8'h80, 64'h1000_0008, 8'd8, 0, 0);
    chk("R13 new entry hit", hit, 1);
    look(S2, 8'h00, 64'h4000_0004, 8'd4, 0, 0);
    chk("R13 slot1 cleared", hit, 0);
    look(S1, 8'h80, 64'h1000_0008, 8'd8, 0, 0);
    chk("R4 old state miss", hit, 0);
  endtask

  task automatic t_inv_fill;
    do_fill(S2, 8'h80, 0, 64'h5000_0000, 64'hFFF, 40'h00_000A_0000, 1, 0, 1);
    look(S2, 8'h80, 64'h5000_0000, 8'd4, 0, 0);
    chk("R14 fill dropped", hit, 0);
    look(S2, 8'h80, 64'h1000_0008, 8'd8, 0, 0);
    chk("R14 cache invalid", hit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_hyp; t_basic; t_write; t_se; t_dup; t_prio; t_implicit; t_inv; t_inv_fill;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired got=hung exp=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule